// File: doc/BRIEF.md
# ATM Cell Header Check Byte Inserter

This block sits on the transmit path of an ATM cell stream. Cells arrive one octet per beat on a valid/ready byte interface, and a start-of-cell marker flags the first octet of each cell. The block counts octets within each 53-octet cell. It runs a CRC-8 over the four leading header octets and writes the result into the fifth octet, which is the header check byte. All other octets go through untouched.

Two control inputs set how the fifth octet is handled. One turns the CRC calculation off, so the upstream value of octet five goes out as it was received. The other applies the fixed 0x55 coset pattern to the computed CRC. The coset makes sure that an all-zero header does not produce an all-zero check byte, so a receiver can still find cell boundaries in long runs of zeros. Both controls are captured on the first octet of each cell and hold for the rest of that cell.

The data path has no register stage. The output handshake mirrors the input, and octets leave in the same cycle they arrive. Back-pressure from downstream reaches upstream directly, and the octet counter stands still while a beat is stalled.

Top module: `atm_hec_tx`

## Requirements
- R1: Every octet other than octet 5 appears on `out_data` unchanged, in the same cycle it is presented on `in_data`.
- R2: `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_soc` equals `in_soc` in every cycle.
- R3: With calculation on and the coset off, octet 5 leaves as the remainder of (header32 * x^8) divided by x^8+x^2+x+1. Here header32 is octets 1 to 4 concatenated with octet 1 as the most significant byte and MSB first within each octet, and the remainder starts from zero for each cell.
- R4: With calculation on and the coset on, octet 5 leaves as the R3 remainder XOR 0x55, so an all-zero header gives 0x55.
- R5: With `cfg_calc_off` = 1, octet 5 leaves exactly as supplied upstream, whatever `cfg_coset_en` is.
- R6: Both control inputs are sampled on the accepted beat of octet 1. Changing them on octets 2 to 53 has no effect on the octet 5 of that cell.
- R7: A cycle without a transfer (`in_valid` = 0 or `out_ready` = 0) does not advance the octet position, so stalls neither drop nor repeat octets.
- R8: An accepted beat with `in_soc` = 1 is always octet 1, even if the previous cell was cut short, and the CRC restarts from it.
- R9: After reset, and after octet 53 of a cell, the next accepted beat is treated as octet 1 even without a start-of-cell marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_calc_off | input | 1 | 1 = leave octet 5 as supplied |
| cfg_coset_en | input | 1 | 1 = XOR 0x55 into the computed check byte |
| in_valid | input | 1 | Upstream octet present |
| in_ready | output | 1 | Block can take the octet |
| in_data | input | 8 | Upstream octet |
| in_soc | input | 1 | Upstream octet is octet 1 of a cell |
| out_valid | output | 1 | Downstream octet present |
| out_ready | input | 1 | Downstream takes the octet |
| out_data | output | 8 | Downstream octet |
| out_soc | output | 1 | Downstream octet is octet 1 of a cell |

## Verification
A wrong octet position shows up within one cell. A substituted byte lands on a payload octet, or the header check byte is left unreplaced, and the fault is visible on `out_data` at the octet where position and data part ways. A corrupted CRC register or a latched control bit shows only on octet 5 of the affected cell, four beats after the first header octet. The bench compares every octet against the computed value under sweeps of header values, control settings, stalls and truncated cells.

// File: rtl/atm_hec_pkg.sv
// Package: shared types and the CRC step for the header check inserter.
// Assumes octet-wide data; the polynomial is passed in by the caller.
package atm_hec_pkg;

    // Per-cell control snapshot
    typedef struct packed {
        logic calc_off;
        logic coset_en;
    } hec_cfg_t;

    // Advance a CRC register over one data word, MSB first
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                             input logic [7:0] data,
                                             input logic [7:0] poly);
        logic [7:0] acc;
        logic       fb;
        acc = crc_in;
        for (int b = 7; b >= 0; b--) begin
            fb  = acc[7] ^ data[b];
            acc = {acc[6:0], 1'b0} ^ (fb ? poly : 8'h00);
        end
        return acc;
    endfunction

endpackage

// File: rtl/atm_hec_octet_ctr.sv
// Octet position tracker.
// Reports the position of the octet on the input (0 = octet 1). A start-of-cell
// marker forces position 0. The position advances only on an accepted beat and
// wraps after the last octet of a cell.
module atm_hec_octet_ctr #(
    parameter int CELL_LEN = 53,
    parameter int IDX_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             soc,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_LEN - 1);

    logic [IDX_W-1:0] cnt_q;
    logic [IDX_W-1:0] cnt_d;

    // Current position: marker overrides the running count
    always_comb begin
        idx   = soc ? '0 : cnt_q;
        cnt_d = (idx == LAST_IDX) ? '0 : idx + IDX_W'(1);
    end

    // Position register, held across stalls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (beat) begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/atm_hec_crc.sv
// Running CRC over the header octets.
// Updates on each accepted header octet. The update starts from zero when
// restart is high, so every cell computes its own remainder. Assumes W = 8.
module atm_hec_crc #(
    parameter int           W    = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic         restart,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc_q
);
    import atm_hec_pkg::*;

    logic [W-1:0] crc_d;

    // Next remainder from either zero or the held value
    always_comb begin
        crc_d = crc8_step(restart ? '0 : crc_q, din, POLY);
    end

    // Remainder register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (upd) begin
            crc_q <= crc_d;
        end
    end
endmodule

// File: rtl/atm_hec_cfg_hold.sv
// Per-cell control capture.
// Takes a snapshot of the control inputs on the first octet of each cell and
// holds it until the next first octet. Later changes therefore do not reach
// the cell in flight.
module atm_hec_cfg_hold (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  atm_hec_pkg::hec_cfg_t  cfg_live,
    output atm_hec_pkg::hec_cfg_t  cfg_q
);
    // Snapshot register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (capture) begin
            cfg_q <= cfg_live;
        end
    end
endmodule

// File: rtl/atm_hec_tx.sv
// Transmit-side header check byte inserter.
// Streams cells through with no added latency. It computes a CRC over header
// octets 1..HDR_LEN and replaces octet HDR_LEN+1 with it, with or without the
// coset, unless calculation is switched off for the cell. Assumes octet data
// and a fixed cell length.
module atm_hec_tx #(
    parameter int                DATA_W   = 8,
    parameter int                CELL_LEN = 53,
    parameter int                HDR_LEN  = 4,
    parameter logic [DATA_W-1:0] POLY     = 8'h07,
    parameter logic [DATA_W-1:0] COSET    = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_calc_off,
    input  logic              cfg_coset_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_soc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_soc
);
    import atm_hec_pkg::*;

    localparam int               IDX_W   = $clog2(CELL_LEN);
    localparam logic [IDX_W-1:0] HEC_IDX = IDX_W'(HDR_LEN);

    logic             beat;
    logic [IDX_W-1:0] oct_idx;
    logic             first_oct;
    logic             in_header;
    logic             at_hec;
    logic [DATA_W-1:0] crc_q;
    logic [DATA_W-1:0] hec_byte;
    hec_cfg_t          cfg_live;
    hec_cfg_t          cell_cfg;

    // Handshake mirrors straight through; a beat is a transfer
    always_comb begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_soc   = in_soc;
        beat      = in_valid && out_ready;
    end

    // Position decode
    always_comb begin
        first_oct = (oct_idx == '0);
        in_header = (oct_idx < HEC_IDX);
        at_hec    = (oct_idx == HEC_IDX);
        cfg_live  = '{calc_off: cfg_calc_off, coset_en: cfg_coset_en};
    end

    atm_hec_octet_ctr #(
        .CELL_LEN (CELL_LEN),
        .IDX_W    (IDX_W)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .beat  (beat),
        .soc   (in_soc),
        .idx   (oct_idx)
    );

    atm_hec_crc #(
        .W    (DATA_W),
        .POLY (POLY)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (beat && in_header),
        .restart (first_oct),
        .din     (in_data),
        .crc_q   (crc_q)
    );

    atm_hec_cfg_hold u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (beat && first_oct),
        .cfg_live (cfg_live),
        .cfg_q    (cell_cfg)
    );

    // Check byte with optional coset
    always_comb begin
        hec_byte = crc_q ^ (cell_cfg.coset_en ? COSET : '0);
    end

    // Output data select: substitute only the check byte position
    always_comb begin
        out_data = (at_hec && !cell_cfg.calc_off) ? hec_byte : in_data;
    end
endmodule

// File: rtl/atm_hec_tx_chk.sv
// Checker for atm_hec_tx, attached by bind. It watches the port handshake, the
// octet position and the per-cell control snapshot.
module atm_hec_tx_chk #(
    parameter int DATA_W   = 8,
    parameter int CELL_LEN = 53,
    parameter int HDR_LEN  = 4,
    parameter int IDX_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_soc,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [IDX_W-1:0]  idx,
    input logic [IDX_W-1:0]  cnt,
    input logic              calc_off
);
    localparam logic [IDX_W-1:0] HEC_IDX = IDX_W'(HDR_LEN);
    localparam logic [IDX_W-1:0] LEN_V   = IDX_W'(CELL_LEN);

    // R1
    payload_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && idx != HEC_IDX) |-> out_data == in_data);

    // R2
    handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready == out_ready) && (out_valid == in_valid));

    // R5
    calc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && idx == HEC_IDX && calc_off) |-> out_data == in_data);

    // R6
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_ready && !in_soc && cnt != '0) |=> $stable(calc_off));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && out_ready) |=> $stable(cnt));

    // R8
    soc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_ready && in_soc) |=> cnt == IDX_W'(1));

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < LEN_V);
endmodule

bind atm_hec_tx atm_hec_tx_chk #(
    .DATA_W   (DATA_W),
    .CELL_LEN (CELL_LEN),
    .HDR_LEN  (HDR_LEN),
    .IDX_W    (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_soc    (in_soc),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .idx       (oct_idx),
    .cnt       (u_ctr.cnt_q),
    .calc_off  (cell_cfg.calc_off)
);

// File: tb/atm_hec_tx_tb.sv
module atm_hec_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_calc_off = 1'b0;
    logic       cfg_coset_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_soc = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_soc;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    int unsigned lcg    = 32'h1234_5678;

    always #10 clk = ~clk;

    atm_hec_tx u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_calc_off (cfg_calc_off),
        .cfg_coset_en (cfg_coset_en),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .in_soc       (in_soc),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_soc      (out_soc)
    );

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Remainder of header*x^8 by 0x107, by long division
    function automatic logic [7:0] hec_ref(input logic [31:0] hdr);
        logic [39:0] r;
        r = {hdr, 8'h00};
        for (int i = 39; i >= 8; i--) begin
            if (r[i]) r = r ^ (40'h107 << (i - 8));
        end
        return r[7:0];
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Send one cell of len octets; checks every octet at the ports
    task automatic send_cell(input logic [31:0] hdr, input logic [7:0] o5,
                             input int len, input bit with_soc,
                             input bit coff, input bit cos,
                             input bit flip, input bit stall);
        logic [7:0] d, e;
        logic [31:0] r;
        string tag;
        for (int k = 0; k < len; k++) begin
            if (k < 4)       d = hdr[31 - 8*k -: 8];
            else if (k == 4) d = o5;
            else             d = 8'(k * 37 + hdr[7:0]);
            r = rnd();
            @(negedge clk);
            if (stall && r[3]) begin
                in_valid = 1'b0;
                #1 chk(out_valid == 1'b0, "R2 idle", {7'h0, out_valid}, 8'h00);
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = d;
            in_soc   = with_soc && (k == 0);
            cfg_calc_off = (k != 0 && flip) ? ~coff : coff;
            cfg_coset_en = (k != 0 && flip) ? ~cos  : cos;
            if (stall && r[7]) begin
                out_ready = 1'b0;
                #1 chk(in_ready == 1'b0, "R7 stall", {7'h0, in_ready}, 8'h00);
                @(negedge clk);
                out_ready = 1'b1;
            end
            #1;
            if (k == 4 && !coff) begin
                e   = hec_ref(hdr) ^ (cos ? 8'h55 : 8'h00);
                tag = cos ? "R4" : "R3";
            end else begin
                e   = d;
                tag = (k == 4) ? "R5" : "R1";
            end
            if (flip && k == 4) tag = {tag, "/R6"};
            chk(out_data == e && out_valid && in_ready, tag, out_data, e);
            chk(out_soc == in_soc, "R2 soc", {7'h0, out_soc}, {7'h0, in_soc});
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_soc   = 1'b0;
    endtask

    task automatic run_all();
        logic [31:0] h, r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 chk(out_valid == 1'b0 && in_ready == 1'b1, "R2 reset",
               {6'h0, out_valid, in_ready}, 8'h01);
        rst_n = 1'b1;
        // R9: first cell after reset without marker; idle header with coset -> 0x52
        send_cell(32'h0000_0001, 8'hAA, 53, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        // R4: all-zero header with coset -> 0x55
        send_cell(32'h0, 8'h00, 53, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        // Sweep last header octet and all control/flip/stall combinations
        for (int v = 0; v < 256; v++) begin
            h = {8'(v ^ 8'h3C), 8'h00, 8'(v * 3), 8'(v)};
            send_cell(h, ~8'(v), 53, (v % 16) != 5, v[0], v[1], v[2], v[3]);
        end
        // Walking-one headers
        for (int b = 0; b < 32; b++) begin
            send_cell(32'h1 << b, 8'h0F, 53, 1'b1, 1'b0, b[0], 1'b0, b[1]);
        end
        // Pseudo-random headers and settings
        for (int n = 0; n < 64; n++) begin
            h = rnd();
            r = rnd();
            send_cell(h, r[15:8], 53, 1'b1, r[0], r[1], r[2], r[3]);
        end
        // R8: truncated cells, then a marked cell must be processed afresh
        send_cell(32'hDEAD_BEEF, 8'h11, 20, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        send_cell(32'h0102_0304, 8'h22, 53, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        send_cell(32'hFFFF_FFFF, 8'h33, 3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        send_cell(32'hCAFE_0042, 8'h44, 53, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        // R9: cell right after a full cell, no marker
        send_cell(32'h8000_0001, 8'h55, 53, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule